// File: doc/BRIEF.md
# PTP One-Step Egress Timestamp Inserter

This block sits on the transmit side of a 64-bit packet stream that uses start, end, valid and ready. A frame may be marked at its start-of-packet beat to receive one-step timing edits. The block can write a transmit timestamp at a chosen byte offset, or update the correction field at a second offset, or do both. Frames without a mark pass through unchanged.

The timestamp comes from a free-running time-of-day input with seconds, nanoseconds and fractional nanoseconds. It is sampled when the start-of-packet beat is accepted. The block then adds the PHY path delay, which arrives as a fixed-point count of clock cycles. Two layouts are available: a 10-byte one and an 8-byte one. A residence-time option adds the difference between the egress time and a per-frame ingress time to the 64-bit correction field already in the frame.

Because the correction field can straddle two beats and carries run from its low bytes back toward its high bytes, the block holds each beat until the next beat (or the frame end) is present. Fields are big-endian. Byte 0 of a beat is bits 63:56, and frame byte 8k+j sits in lane j of beat k.

Top module: `ptp_onestep_inserter`

## Requirements
- R1: A frame whose start beat has both `inInsert` and `inResUpd` low leaves the block bit-for-bit unchanged. Beat order, data, `outSop` and `outEop` are all preserved.
- R2: `inInsert`, `inFmt`, `inResUpd`, both offsets and `inIngressNs` are used only from the accepted start beat. Their values on any other beat have no effect on the output.
- R3: With insert and `inFmt`=0, the 48-bit seconds value is written at `inTsOff`, followed at once by the 32-bit nanoseconds value (10 bytes, big-endian). Without a residence update, bits 15:0 of the correction field at `inCorrOff` are replaced by the fractional nanoseconds, and bits 63:16 are kept.
- R4: With insert and `inFmt`=1, bits 31:0 of the seconds value are written at `inTsOff`, followed by the 32-bit nanoseconds value (8 bytes). The correction field is not touched unless R5 applies.
- R5: With `inResUpd`=1, the 64-bit correction field becomes its old value plus ((egressNs − `inIngressNs`) << 16) + fracNs, modulo 2^64. Here egressNs = seconds·10^9 + nanoseconds of the compensated time. In this case R3's fraction placement is not applied.
- R6: The compensated time, in units of 2^-16 ns, is the sampled {ns, frac} plus `pathDelay`·`CLK_PERIOD_Q6`. In `pathDelay`, bits 9:0 are fractional cycles and the upper bits are whole cycles. `CLK_PERIOD_Q6` is the clock period in units of 1/64 ns.
- R7: When the compensated nanoseconds reach 10^9 or more, 10^9 is subtracted and the seconds value increments, wrapping modulo 2^48.
- R8: Both fields may start at any byte lane and may span two beats. Either field may be edited on any beat of the frame.
- R9: No beat is lost or duplicated under any pattern of valid and ready. While `outValid` is high and `outReady` is low, the output is held. With continuous input and `outReady` high, `inReady` never drops.
- R10: After reset, `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block accepts the input beat |
| inData | input | 64 | Input beat, byte 0 in bits 63:56 |
| inSop | input | 1 | First beat of a frame |
| inEop | input | 1 | Last beat of a frame |
| inInsert | input | 1 | Insert timestamp (start beat only) |
| inFmt | input | 1 | 0: 10-byte layout, 1: 8-byte layout |
| inResUpd | input | 1 | Add residence time into correction field |
| inTsOff | input | 11 | Byte offset of timestamp field |
| inCorrOff | input | 11 | Byte offset of correction field |
| inIngressNs | input | 64 | Ingress time in nanoseconds |
| todSec | input | 48 | Time of day, seconds |
| todNs | input | 32 | Time of day, nanoseconds (< 10^9) |
| todFrac | input | 16 | Time of day, fractional nanoseconds |
| pathDelay | input | 22 | Path delay, fixed-point clock cycles |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts |
| outData | output | 64 | Output beat |
| outSop | output | 1 | First beat of a frame |
| outEop | output | 1 | Last beat of a frame |

## Verification
The bench uses the default parameters: 8-byte beats, 11-bit offsets, a 22-bit path delay and `CLK_PERIOD_Q6`=320, which is a 5 ns period. Header offsets from 0 to 20 put both fields at every lane alignment, so every two-beat split of the correction and timestamp fields is exercised. Random path delays of up to about 20 µs, combined with nanoseconds near 10^9 and directed seconds at all ones, reach the nanosecond carry, an exact hit on 10^9 and the 48-bit seconds wrap. A fractional delay applied to a fraction of 0xFFFF drives a carry from the fraction into the nanoseconds.

// File: rtl/ptp_ins_pkg.sv
package ptp_ins_pkg;
  localparam logic [63:0] NS_PER_SEC = 64'd1000000000;

  typedef struct packed {
    logic capA;
    logic moveAB;
    logic frameB;
    logic fire;
  } ptpStrobe_t;
endpackage

// File: rtl/ptp_ins_ctrl.sv
module ptp_ins_ctrl
  import ptp_ins_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSop,
  input  logic             inEop,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output logic             outSop,
  output logic             outEop,
  output ptpStrobe_t       strobe,
  output logic [IDX_W-1:0] beatIdx
);
  logic aV, aSop, aEop, bV, bSop, bEop;
  logic shift, capA;

  // a beat is released only when its successor is held or it closes the frame
  assign outValid = bV && (aV || bEop);
  assign shift    = !bV || (outValid && outReady);
  assign inReady  = shift || !aV;
  assign capA     = inValid && inReady;
  assign outSop   = bSop;
  assign outEop   = bEop;

  assign strobe.capA   = capA;
  assign strobe.moveAB = shift && aV;
  assign strobe.frameB = shift && aV && aSop;
  assign strobe.fire   = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aV <= 1'b0; aSop <= 1'b0; aEop <= 1'b0;
      bV <= 1'b0; bSop <= 1'b0; bEop <= 1'b0;
      beatIdx <= '0;
    end else if (shift) begin
      bV   <= aV;
      bSop <= aSop;
      bEop <= aEop;
      if (aV) beatIdx <= aSop ? '0 : beatIdx + 1'b1;
      aV   <= capA;
      aSop <= inSop;
      aEop <= inEop;
    end else if (capA) begin
      aV   <= 1'b1;
      aSop <= inSop;
      aEop <= inEop;
    end
  end

  assert_first_idx_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop) |-> (beatIdx == '0));
endmodule

// File: rtl/ptp_ins_datapath.sv
module ptp_ins_datapath
  import ptp_ins_pkg::*;
#(
  parameter int BEAT_BYTES    = 8,
  parameter int OFF_W         = 11,
  parameter int PD_W          = 22,
  parameter int CLK_PERIOD_Q6 = 320,
  localparam int DW    = 8 * BEAT_BYTES,
  localparam int LB    = $clog2(BEAT_BYTES),
  localparam int IDX_W = OFF_W - LB,
  localparam int WIN_W = 2 * DW
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptpStrobe_t       strobe,
  input  logic [IDX_W-1:0] beatIdx,
  input  logic [DW-1:0]    inData,
  input  logic             inSop,
  input  logic             inInsert,
  input  logic             inFmt,
  input  logic             inResUpd,
  input  logic [OFF_W-1:0] inTsOff,
  input  logic [OFF_W-1:0] inCorrOff,
  input  logic [63:0]      inIngressNs,
  input  logic [47:0]      todSec,
  input  logic [31:0]      todNs,
  input  logic [15:0]      todFrac,
  input  logic [PD_W-1:0]  pathDelay,
  output logic [DW-1:0]    outData
);
  logic [DW-1:0] aData, bData;
  logic aIns, aFmt, aRes, bIns, bFmt, bRes;
  logic [OFF_W-1:0] aTsOff, aCorrOff, bTsOff, bCorrOff;
  logic [63:0] aIngr, bIngr;
  logic [47:0] aSec, bSec, capSec;
  logic [31:0] aNs, bNs, capNs;
  logic [15:0] aFrac, bFrac;

  // path-delay compensation on the sampled time of day
  logic [63:0] delayQ16, sumQ16;
  logic        nsWrap;
  assign delayQ16 = 64'(pathDelay) * 64'(CLK_PERIOD_Q6);
  assign sumQ16   = {16'd0, todNs, todFrac} + delayQ16;
  assign nsWrap   = {16'd0, sumQ16[63:16]} >= NS_PER_SEC;
  assign capNs    = nsWrap ? 32'(sumQ16[47:16] - NS_PER_SEC[31:0]) : sumQ16[47:16];
  assign capSec   = todSec + 48'(nsWrap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aData <= '0; bData <= '0;
      {aIns, aFmt, aRes, bIns, bFmt, bRes} <= '0;
      {aTsOff, aCorrOff, bTsOff, bCorrOff} <= '0;
      {aIngr, bIngr} <= '0;
      {aSec, aNs, aFrac, bSec, bNs, bFrac} <= '0;
    end else begin
      if (strobe.capA) aData <= inData;
      if (strobe.capA && inSop) begin
        aIns <= inInsert; aFmt <= inFmt; aRes <= inResUpd;
        aTsOff <= inTsOff; aCorrOff <= inCorrOff; aIngr <= inIngressNs;
        aSec <= capSec; aNs <= capNs; aFrac <= sumQ16[15:0];
      end
      if (strobe.moveAB) bData <= aData;
      if (strobe.frameB) begin
        bIns <= aIns; bFmt <= aFmt; bRes <= aRes;
        bTsOff <= aTsOff; bCorrOff <= aCorrOff; bIngr <= aIngr;
        bSec <= aSec; bNs <= aNs; bFrac <= aFrac;
      end
    end
  end

  // correction field: read old value across the two held beats, modify
  logic [WIN_W-1:0] win;
  logic [63:0] egressNs, resid, oldCorr, corrComb, corrReg, corrSel;
  logic [LB-1:0] relC;
  logic corrHere, corrEn;
  logic [79:0] tsVec;
  logic [3:0]  tsLen;

  assign win      = {bData, aData};
  assign relC     = bCorrOff[LB-1:0];
  assign corrHere = (bCorrOff[OFF_W-1:LB] == beatIdx);
  assign oldCorr  = 64'(win >> (WIN_W - 64 - 8 * int'(relC)));
  assign egressNs = 64'(bSec) * NS_PER_SEC + 64'(bNs);
  assign resid    = ((egressNs - bIngr) << 16) + 64'(bFrac);
  assign corrComb = bRes ? oldCorr + resid : {oldCorr[63:16], bFrac};
  assign corrSel  = corrHere ? corrComb : corrReg;
  assign corrEn   = bRes || (bIns && !bFmt);
  assign tsVec    = bFmt ? {bSec[31:0], bNs, 16'd0} : {bSec, bNs};
  assign tsLen    = bFmt ? 4'd8 : 4'd10;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) corrReg <= '0;
    else if (strobe.fire && corrHere) corrReg <= corrComb;
  end

  for (genvar i = 0; i < BEAT_BYTES; i++) begin : gLane
    localparam logic [LB-1:0] LANE = LB'(i);
    logic [OFF_W-1:0] pos, dTs, dC;
    logic inTs, inC;
    logic [7:0] tsByte, cByte;
    assign pos    = {beatIdx, LANE};
    assign dTs    = pos - bTsOff;
    assign dC     = pos - bCorrOff;
    assign inTs   = bIns && (pos >= bTsOff) && (dTs < OFF_W'(tsLen));
    assign inC    = corrEn && (pos >= bCorrOff) && (dC < OFF_W'(8));
    assign tsByte = 8'(tsVec >> ({3'd0, 4'd9 - dTs[3:0]} << 3));
    assign cByte  = 8'(corrSel >> ({3'd0, 3'd7 - dC[2:0]} << 3));
    assign outData[DW-1-8*i -: 8] = inC ? cByte : (inTs ? tsByte : bData[DW-1-8*i -: 8]);
  end

  assert_ns_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capA && inSop && (64'(todNs) < NS_PER_SEC)) |=> (64'(aNs) < NS_PER_SEC));

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && !bIns && !bRes) |-> (outData == bData));
endmodule

// File: rtl/ptp_onestep_inserter.sv
module ptp_onestep_inserter
  import ptp_ins_pkg::*;
#(
  parameter int BEAT_BYTES    = 8,
  parameter int OFF_W         = 11,
  parameter int PD_W          = 22,
  parameter int CLK_PERIOD_Q6 = 320,
  localparam int DW    = 8 * BEAT_BYTES,
  localparam int IDX_W = OFF_W - $clog2(BEAT_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [DW-1:0]    inData,
  input  logic             inSop,
  input  logic             inEop,
  input  logic             inInsert,
  input  logic             inFmt,
  input  logic             inResUpd,
  input  logic [OFF_W-1:0] inTsOff,
  input  logic [OFF_W-1:0] inCorrOff,
  input  logic [63:0]      inIngressNs,
  input  logic [47:0]      todSec,
  input  logic [31:0]      todNs,
  input  logic [15:0]      todFrac,
  input  logic [PD_W-1:0]  pathDelay,
  output logic             outValid,
  input  logic             outReady,
  output logic [DW-1:0]    outData,
  output logic             outSop,
  output logic             outEop
);
  ptpStrobe_t       strobe;
  logic [IDX_W-1:0] beatIdx;

  ptp_ins_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .outSop(outSop), .outEop(outEop), .strobe(strobe), .beatIdx(beatIdx)
  );

  ptp_ins_datapath #(
    .BEAT_BYTES(BEAT_BYTES), .OFF_W(OFF_W), .PD_W(PD_W), .CLK_PERIOD_Q6(CLK_PERIOD_Q6)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .beatIdx(beatIdx),
    .inData(inData), .inSop(inSop), .inInsert(inInsert), .inFmt(inFmt),
    .inResUpd(inResUpd), .inTsOff(inTsOff), .inCorrOff(inCorrOff),
    .inIngressNs(inIngressNs), .todSec(todSec), .todNs(todNs), .todFrac(todFrac),
    .pathDelay(pathDelay), .outData(outData)
  );

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSop) && $stable(outEop)));
endmodule

// File: tb/ptp_onestep_inserter_tb.sv
module ptp_onestep_inserter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady, inSop = 1'b0, inEop = 1'b0;
  logic [63:0] inData = '0;
  logic inInsert = 1'b0, inFmt = 1'b0, inResUpd = 1'b0;
  logic [10:0] inTsOff = '0, inCorrOff = '0;
  logic [63:0] inIngressNs = '0;
  logic [47:0] todSec = '0;
  logic [31:0] todNs = '0;
  logic [15:0] todFrac = '0;
  logic [21:0] pathDelay = '0;
  logic outValid, outReady = 1'b0, outSop, outEop;
  logic [63:0] outData;

  always #2.5 clk = ~clk;   // 200 MHz

  ptp_onestep_inserter #(.BEAT_BYTES(8), .OFF_W(11), .PD_W(22), .CLK_PERIOD_Q6(320)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inSop(inSop), .inEop(inEop), .inInsert(inInsert), .inFmt(inFmt), .inResUpd(inResUpd),
    .inTsOff(inTsOff), .inCorrOff(inCorrOff), .inIngressNs(inIngressNs),
    .todSec(todSec), .todNs(todNs), .todFrac(todFrac), .pathDelay(pathDelay),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSop(outSop), .outEop(outEop)
  );

  int nChk = 0, nBad = 0, stallCnt = 0;
  bit rstDone = 0, burst = 0, finished = 0;
  logic [65:0] expQ[$];
  string tagQ[$];
  logic [7:0] frm [0:79];
  logic [7:0] expB[0:79];

  task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compTime(input [47:0] s, input [31:0] n, input [15:0] f, input [21:0] pd,
                          output [47:0] so, output [31:0] no, output [15:0] fo);
    longint unsigned q, ns;
    q  = ({32'd0, n, f}) + longint'(pd) * 320;
    ns = q >> 16;
    fo = q[15:0];
    if (ns >= 64'd1000000000) begin ns -= 64'd1000000000; so = s + 48'd1; end
    else so = s;
    no = ns[31:0];
  endtask

  task automatic buildExp(input int len, input bit ins, input bit fmt, input bit res,
                          input int tsOff, input int cOff, input [63:0] ingr);
    logic [47:0] cs; logic [31:0] cn; logic [15:0] cf;
    logic [79:0] tv; logic [63:0] oc, nc, egr;
    compTime(todSec, todNs, todFrac, pathDelay, cs, cn, cf);
    for (int k = 0; k < len; k++) expB[k] = frm[k];
    if (ins) begin
      tv = fmt ? {cs[31:0], cn, 16'd0} : {cs, cn};
      for (int k = 0; k < (fmt ? 8 : 10); k++) expB[tsOff + k] = tv[79 - 8*k -: 8];
    end
    if (res || (ins && !fmt)) begin
      oc = '0;
      for (int k = 0; k < 8; k++) oc = {oc[55:0], frm[cOff + k]};
      egr = 64'(cs) * 64'd1000000000 + 64'(cn);
      nc = res ? oc + ((egr - ingr) << 16) + 64'(cf) : {oc[63:16], cf};
      for (int k = 0; k < 8; k++) expB[cOff + k] = nc[63 - 8*k -: 8];
    end
  endtask

  task automatic randTod();
    todSec = {$urandom, $urandom} ; todNs = $urandom % 1000000000;
    todFrac = 16'($urandom); pathDelay = 22'($urandom);
  endtask

  task automatic sendFrame(input int len, input bit ins, input bit fmt, input bit res, input int hdr,
                           input bit dirTod, input [47:0] dSec, input [31:0] dNs,
                           input [15:0] dFrac, input [21:0] dPd, input bit gaps);
    logic [63:0] ingr;
    string tag;
    int cOff, tsOff;
    cOff = hdr + 8; tsOff = hdr + 34;
    ingr = {$urandom, $urandom};
    for (int k = 0; k < len; k++) frm[k] = 8'($urandom);
    if (!ins && !res) tag = "R1 R2";
    else if (res) tag = "R5 R6 R8";
    else if (fmt) tag = "R4 R8";
    else tag = "R3 R6 R7 R8";
    for (int b = 0; b < len / 8; b++) begin
      bit acc = 0;
      while (!acc) begin
        @(negedge clk);
        inValid = gaps ? ($urandom % 4 != 0) : 1'b1;
        for (int j = 0; j < 8; j++) inData[63 - 8*j -: 8] = frm[8*b + j];
        inSop = (b == 0); inEop = (b == len / 8 - 1);
        randTod();
        if (b == 0) begin
          inInsert = ins; inFmt = fmt; inResUpd = res;
          inTsOff = 11'(tsOff); inCorrOff = 11'(cOff); inIngressNs = ingr;
          if (dirTod) begin todSec = dSec; todNs = dNs; todFrac = dFrac; pathDelay = dPd; end
        end else begin   // junk controls off the start beat (R2)
          inInsert = 1'($urandom); inFmt = 1'($urandom); inResUpd = 1'($urandom);
          inTsOff = 11'($urandom); inCorrOff = 11'($urandom); inIngressNs = {$urandom, $urandom};
        end
        #3;
        acc = inValid && inReady;
        if (!acc && burst) stallCnt++;
        if (acc && b == 0) begin
          buildExp(len, ins, fmt, res, tsOff, cOff, ingr);
          for (int q = 0; q < len / 8; q++) begin
            logic [63:0] d;
            for (int j = 0; j < 8; j++) d[63 - 8*j -: 8] = expB[8*q + j];
            expQ.push_back({q == 0, q == len / 8 - 1, d});
            tagQ.push_back(tag);
          end
        end
      end
    end
    if (!burst) begin @(negedge clk); inValid = 1'b0; end
  endtask

  // output monitor
  initial begin
    wait (rstDone);
    forever begin
      @(negedge clk);
      outReady = burst ? 1'b1 : ($urandom % 4 != 0);
      #2;
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R9 unexpected beat", {outSop, outEop, outData}, '0);
        else begin
          logic [65:0] e; string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          check(e === {outSop, outEop, outData}, t, {outSop, outEop, outData}, e);
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!outValid && inReady, "R10 reset state", {64'd0, outValid, inReady}, {64'd0, 2'b01});
    rstDone = 1;
    // directed corners
    sendFrame(56, 0, 0, 0, 3, 0, 0, 0, 0, 0, 1);                                  // R1 R2 pass-through
    sendFrame(56, 1, 0, 0, 3, 1, 48'd77, 32'd999999990, 16'd0, 22'd3 << 10, 0);   // R7 carry, R8 span
    sendFrame(64, 1, 0, 0, 13, 1, 48'd5, 32'd999999985, 16'd0, 22'd3 << 10, 0);   // R7 exact 10^9
    sendFrame(56, 1, 0, 0, 0, 1, 48'hFFFF_FFFF_FFFF, 32'd999999999, 16'd0, 22'd1 << 10, 1); // R7 wrap
    sendFrame(64, 1, 0, 0, 7, 1, 48'd9, 32'd12345, 16'hFFFF, 22'd1, 0);          // R6 frac carry
    sendFrame(64, 1, 1, 0, 5, 0, 0, 0, 0, 0, 1);                                  // R4
    sendFrame(64, 0, 0, 1, 10, 0, 0, 0, 0, 0, 1);                                 // R5 only
    sendFrame(64, 1, 0, 1, 20, 1, 48'd100, 32'd500, 16'h8000, 22'd0, 0);         // R3 with R5
    // random frames
    for (int n = 0; n < 120; n++) begin
      int hdr, len;
      hdr = $urandom % 21;
      len = ((hdr + 44 + 7) / 8) * 8 + 8 * ($urandom % 2);
      sendFrame(len, 1'($urandom), 1'($urandom), 1'($urandom), hdr, 0, 0, 0, 0, 0, 1);
    end
    // R9 back-to-back burst
    burst = 1;
    repeat (8) @(negedge clk);
    stallCnt = 0;
    for (int n = 0; n < 4; n++) sendFrame(64, 1'(n), 1'(n >> 1), 1'(n), 2 * n, 0, 0, 0, 0, 0, 0);
    @(negedge clk); inValid = 1'b0;
    check(stallCnt == 0, "R9 no stall with continuous flow", 66'(stallCnt), 66'd0);
    burst = 0;
    for (int w = 0; w < 2000 && expQ.size() != 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9 all beats delivered", 66'(expQ.size()), 66'd0);
    finishRun();
  end
endmodule